// File: doc/BRIEF.md
# Hiccup Current-Limit Controller

This block decides when a buck converter's switching must halt because overcurrent has persisted, and when it may try again. Once per switching cycle it receives a strobe together with the overcurrent comparator result. It keeps an asymmetric score that gains two points on a cycle with overcurrent and loses one point on a clean cycle. An isolated overcurrent cycle therefore fades away. A sustained burst trips the block when the score reaches sixteen, which takes eight overcurrent cycles in a row starting from zero.

When it trips, the block raises a shutdown flag. It then counts a fixed number of microsecond ticks, 8000 by default for an 8 ms pause. After that it drops the flag and sends a one-cycle restart request, so the sequencer runs a fresh soft-start. The score is cleared at the restart. Tripping does not raise any system fault indication. Separately, on every cycle where overcurrent is seen while switching is allowed, the block asks for the current cycle to be cut short.

At start-up the block keeps a measurement-enable output high until one sample of the limit-select level arrives. That sample fixes which of the two current-limit thresholds applies. The enable then goes low and the choice holds until reset.

Top module: `hcl_hiccup_ctrl`

## Requirements
- R1: Directly after synchronous reset, `shutdown` = 0, `restart_req` = 0, `thr_code` = 0 (lower limit) and `meas_on` = 1.
- R2: A cycle with `cyc_strobe` = 1 and `oc_flag` = 1, while `shutdown` = 0, adds 2 to the score, saturating at 16. When the score reaches 16, `shutdown` rises on that clock edge. From a score of zero, seven such cycles do not trip and the eighth does. With `cyc_strobe` = 0, `oc_flag` has no effect on the score.
- R3: A strobed cycle with `oc_flag` = 0 subtracts 1 from the score. The score never goes below 0.
- R4: A sparse pattern of one overcurrent cycle in every three strobes never raises `shutdown`.
- R5: While `shutdown` = 1, strobes are ignored. `shutdown` stays high for exactly WAIT_US clock edges at which `us_tick` = 1, and falls on the edge of the last of those ticks.
- R6: On the edge where `shutdown` falls, `restart_req` goes to 1 for exactly one cycle and the score returns to 0. At all other times `restart_req` = 0.
- R7: `cut_cycle` = `oc_flag` whenever `shutdown` = 0, and `cut_cycle` = 0 whenever `shutdown` = 1.
- R8: The first `thr_sample` = 1 after reset loads `thr_level` into `thr_code` (1 = higher limit, 0 = lower limit) and drops `meas_on` to 0. Later samples leave `thr_code` unchanged, including across hiccup restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | One pulse per switching cycle |
| oc_flag | input | 1 | Overcurrent comparator result for this cycle |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| thr_sample | input | 1 | Strobe marking a valid limit-select level |
| thr_level | input | 1 | Measured limit-select level |
| shutdown | output | 1 | Switching halted (hiccup wait) |
| restart_req | output | 1 | One-cycle request to rerun soft-start |
| cut_cycle | output | 1 | Truncate the present switching cycle |
| thr_code | output | 1 | Selected current-limit threshold |
| meas_on | output | 1 | Limit-select measurement source enabled |

## Verification
The checker watches, on every cycle, the properties that can be stated locally. The restart request is always a single-cycle pulse, and it only ever coincides with the falling edge of shutdown. Shutdown can only rise after a strobed overcurrent cycle. The cycle-cut output is gated off during the wait. The threshold code cannot move once the measurement has been switched off. The score arithmetic can only be shown by the bench's scenarios, which run a cycle-by-cycle model. Those scenarios cover exact trip points under burst, sparse, saturating and pseudo-random patterns, the exact tick count of each wait, and the fact that the score is cleared after a restart.

// File: rtl/hcl_pkg.sv
package hcl_pkg;

    typedef enum logic {
        LIM_LOW  = 1'b0,
        LIM_HIGH = 1'b1
    } lim_sel_e;

    // Next score value for one strobed cycle, saturating at both ends.
    function automatic int score_next(int cur, logic oc, int up, int dn, int lim);
        int n;
        if (oc) begin
            n = cur + up;
            if (n > lim) n = lim;
        end else begin
            n = (cur >= dn) ? cur - dn : 0;
        end
        return n;
    endfunction

endpackage

// File: rtl/hcl_thr_latch.sv
module hcl_thr_latch
    import hcl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sample,
    input  logic     level,
    output lim_sel_e code,
    output logic     meas_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code    <= LIM_LOW;
            meas_on <= 1'b1;
        end else if (sample && meas_on) begin
            code    <= lim_sel_e'(level);
            meas_on <= 1'b0;
        end
    end
endmodule

// File: rtl/hcl_oc_counter.sv
module hcl_oc_counter
    import hcl_pkg::*;
#(
    parameter int LIMIT = 16,
    parameter int UP    = 2,
    parameter int DN    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic oc,
    input  logic hold,
    input  logic clear,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] score_q;
    int            nxt;
    logic          live;

    assign live = strobe && !hold;

    always_comb begin
        nxt  = score_next(int'(score_q), oc, UP, DN, LIMIT);
        trip = live && (nxt >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            score_q <= '0;
        end else if (live) begin
            score_q <= CW'(nxt);
        end
    end
endmodule

// File: rtl/hcl_wait_timer.sv
module hcl_wait_timer #(
    parameter int WAIT_US = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic tick,
    output logic shutdown,
    output logic restart_req,
    output logic done
);
    localparam int WW = $clog2(WAIT_US + 1);
    localparam logic [WW-1:0] LAST = WW'(WAIT_US - 1);

    logic [WW-1:0] wcnt_q;

    assign done = shutdown && tick && (wcnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shutdown    <= 1'b0;
            restart_req <= 1'b0;
            wcnt_q      <= '0;
        end else begin
            restart_req <= done;
            if (trip) begin
                shutdown <= 1'b1;
                wcnt_q   <= '0;
            end else if (done) begin
                shutdown <= 1'b0;
                wcnt_q   <= '0;
            end else if (shutdown && tick) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hcl_hiccup_ctrl.sv
module hcl_hiccup_ctrl
    import hcl_pkg::*;
#(
    parameter int LIMIT   = 16,
    parameter int UP      = 2,
    parameter int DN      = 1,
    parameter int WAIT_US = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_strobe,
    input  logic oc_flag,
    input  logic us_tick,
    input  logic thr_sample,
    input  logic thr_level,
    output logic shutdown,
    output logic restart_req,
    output logic cut_cycle,
    output logic thr_code,
    output logic meas_on
);
    logic     trip;
    logic     done;
    lim_sel_e code;

    hcl_oc_counter #(.LIMIT(LIMIT), .UP(UP), .DN(DN)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .strobe(cyc_strobe),
        .oc    (oc_flag),
        .hold  (shutdown),
        .clear (done),
        .trip  (trip)
    );

    hcl_wait_timer #(.WAIT_US(WAIT_US)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .trip       (trip),
        .tick       (us_tick),
        .shutdown   (shutdown),
        .restart_req(restart_req),
        .done       (done)
    );

    hcl_thr_latch u_thr (
        .clk    (clk),
        .rst    (rst),
        .sample (thr_sample),
        .level  (thr_level),
        .code   (code),
        .meas_on(meas_on)
    );

    assign thr_code  = code;
    assign cut_cycle = oc_flag && !shutdown;
endmodule

// File: rtl/hcl_hiccup_chk.sv
module hcl_hiccup_chk (
    input logic clk,
    input logic rst,
    input logic cyc_strobe,
    input logic oc_flag,
    input logic shutdown,
    input logic restart_req,
    input logic cut_cycle,
    input logic thr_code,
    input logic meas_on
);
    // R6
    restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> !restart_req);

    // R6
    restart_at_exit_chk: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> ($fell(shutdown)));

    // R5
    exit_requests_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shutdown) |-> restart_req);

    // R2
    trip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(cyc_strobe && oc_flag));

    // R7
    cut_gated_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> !cut_cycle);

    // R8
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !meas_on |=> (!meas_on && $stable(thr_code)));
endmodule

bind hcl_hiccup_ctrl hcl_hiccup_chk u_hiccup_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_strobe (cyc_strobe),
    .oc_flag    (oc_flag),
    .shutdown   (shutdown),
    .restart_req(restart_req),
    .cut_cycle  (cut_cycle),
    .thr_code   (thr_code),
    .meas_on    (meas_on)
);

// File: tb/test_hcl_hiccup_ctrl.sv
`timescale 1ns/1ps
module test_hcl_hiccup_ctrl;
    localparam int LIMIT = 16;
    localparam int WAIT_US = 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_strobe = 1'b0, oc_flag = 1'b0, us_tick = 1'b0;
    logic thr_sample = 1'b0, thr_level = 1'b0;
    logic shutdown, restart_req, cut_cycle, thr_code, meas_on;

    int checks = 0;
    int errors = 0;
    int score = 0;
    bit exp_sd = 1'b0;
    bit finished = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    hcl_hiccup_ctrl i_hcl_hiccup_ctrl (
        .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .oc_flag(oc_flag),
        .us_tick(us_tick), .thr_sample(thr_sample), .thr_level(thr_level),
        .shutdown(shutdown), .restart_req(restart_req), .cut_cycle(cut_cycle),
        .thr_code(thr_code), .meas_on(meas_on)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Apply inputs one time unit after an edge, advance one clock.
    task automatic drive(input bit s, input bit o, input bit t, input bit ts, input bit tl);
        cyc_strobe = s; oc_flag = o; us_tick = t; thr_sample = ts; thr_level = tl;
        #1;
        @(posedge clk);
        #1;
    endtask

    // Normal-operation step, checked against the arithmetic model.
    task automatic step(input bit s, input bit o, input string req);
        cyc_strobe = s; oc_flag = o; us_tick = 1'b1; thr_sample = 1'b0;
        #1;
        chk(cut_cycle == (o && !shutdown), "R7", cut_cycle, o && !shutdown);
        @(posedge clk);
        #1;
        if (s && !exp_sd) begin
            if (o) score = (score + 2 > LIMIT) ? LIMIT : score + 2;
            else   score = (score > 0) ? score - 1 : 0;
            if (score >= LIMIT) exp_sd = 1'b1;
        end
        chk(shutdown == exp_sd, req, shutdown, exp_sd);
        chk(restart_req == 1'b0, "R6", restart_req, 0);
    endtask

    // Wait out a hiccup; ticks applied every tick_div cycles; strobes with oc kept active.
    task automatic hiccup(input int tick_div);
        int ticks = 0;
        int k = 0;
        int bad_cut = 0;
        while (shutdown) begin
            bit t = ((k % tick_div) == 0);
            if (t) ticks++;
            cyc_strobe = 1'b1; oc_flag = 1'b1; us_tick = t;
            #1;
            if (cut_cycle) bad_cut++;
            @(posedge clk);
            #1;
            k++;
        end
        chk(ticks == WAIT_US, "R5", ticks, WAIT_US);
        chk(bad_cut == 0, "R7", bad_cut, 0);
        chk(restart_req == 1'b1, "R6", restart_req, 1);
        drive(0, 0, 0, 0, 0);
        chk(restart_req == 1'b0, "R6", restart_req, 0);
        score = 0;
        exp_sd = 1'b0;
    endtask

    initial begin
        logic [7:0] lf = 8'hA5;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        // R1 reset state
        chk(shutdown == 0, "R1", shutdown, 0);
        chk(restart_req == 0, "R1", restart_req, 0);
        chk(thr_code == 0, "R1", thr_code, 0);
        chk(meas_on == 1, "R1", meas_on, 1);

        // R8 first sample is latched, later ones ignored
        drive(0, 0, 0, 1, 1);
        chk(thr_code == 1, "R8", thr_code, 1);
        chk(meas_on == 0, "R8", meas_on, 0);
        drive(0, 0, 0, 1, 0);
        chk(thr_code == 1, "R8", thr_code, 1);

        // R2 unstrobed overcurrent has no effect, then 8 in a row trip
        for (int i = 0; i < 20; i++) step(0, 1, "R2");
        for (int i = 0; i < 8; i++) step(1, 1, "R2");
        chk(shutdown == 1, "R2", shutdown, 1);
        hiccup(1);

        // R6 score cleared: seven do not trip, eighth does
        for (int i = 0; i < 7; i++) step(1, 1, "R6");
        chk(shutdown == 0, "R6", shutdown, 0);
        step(1, 1, "R6");
        chk(shutdown == 1, "R6", shutdown, 1);
        hiccup(2);

        // R3 floor at zero, then mixed decrement
        for (int i = 0; i < 30; i++) step(1, 0, "R3");
        for (int i = 0; i < 7; i++) step(1, 1, "R3");
        step(1, 0, "R3");
        step(1, 1, "R3");
        step(1, 1, "R3");
        chk(shutdown == 1, "R3", shutdown, 1);
        hiccup(1);

        // R4 sparse pattern never trips
        for (int i = 0; i < 60; i++) begin
            step(1, 1, "R4");
            step(1, 0, "R4");
            step(1, 0, "R4");
        end
        chk(shutdown == 0, "R4", shutdown, 0);

        // R3 pseudo-random sweep against the model
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[0], lf[2:1] == 2'b00 || lf[3:1] == 3'b111, "R3");
            if (exp_sd) hiccup(1);
        end

        // R8 choice held across restarts
        chk(thr_code == 1, "R8", thr_code, 1);
        chk(meas_on == 0, "R8", meas_on, 0);
        finish_run();
    end
endmodule